// File: doc/BRIEF.md
# Immediate-Controlled Vector Element Shuffle

This block rearranges the elements of a 256-bit vector under the control of an 8-bit immediate. The immediate is read as four 2-bit selector fields. Field k sits at immediate bits [2k+1:2k]. A mode input decides how the four fields are applied to the input vectors. In lane dword mode, the pattern picks 32-bit elements inside each 128-bit lane, and both lanes use the same pattern. In qword crossing mode, the fields pick 64-bit elements from anywhere in the register. In dual-source mode, the two low elements of each lane come from source A and the two high elements come from source B.

Each output element has its own multiplexer. The select input of that multiplexer comes from a small generator that turns the mode and the immediate into one index per element. The result is registered, so it appears one clock after a valid input. When no input is valid, the last result stays on the output.

Top module: `vec_shuffle_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset is released, `out_vld` is 0 and `out_data` is all zero.
- R2: `out_vld` is asserted exactly one clock after a cycle with `in_vld` high, and is low one clock after a cycle with `in_vld` low.
- R3: When `mode` = 2'b00 (lane dword), output dword at position k of lane L (dword index 4L+k) equals `src_a` dword 4L + imm[2k+1:2k]. Dword i occupies bits [32i+31:32i].
- R4: In lane dword mode, the upper lane uses the same four fields as the lower lane, and it only selects dwords 4..7.
- R5: When `mode` = 2'b01 (qword crossing), output qword q (bits [64q+63:64q]) equals `src_a` qword imm[2q+1:2q]. Data may move between lanes.
- R6: When `mode` = 2'b10 (dual source), output positions 0 and 1 of lane L take `src_a` dword 4L + field k. Output positions 2 and 3 take `src_b` dword 4L + field k.
- R7: When `mode` = 2'b11 (reserved), the registered result is all zero.
- R8: In modes 2'b00 and 2'b01, the value of `src_b` has no effect on the result.
- R9: While `in_vld` is low, `out_data` holds its previous value whatever the other inputs do.
- R10: Valid inputs on consecutive cycles each produce their own result on the following cycle, with no lost or repeated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input valid strobe |
| mode | input | 2 | Selection geometry: 00 lane dword, 01 qword crossing, 10 dual source, 11 reserved |
| imm | input | 8 | Four 2-bit selector fields |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector, used only in dual-source mode |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| out_data | output | 256 | Registered shuffle result |

## Verification
A result is due one rising edge after the cycle in which its input is presented. The bench drives each input set on a falling edge. It compares `out_vld` and `out_data` on the next falling edge, which follows exactly one rising edge, against a behavioural model that was updated when the input was driven. Idle cycles are checked on the same one-edge schedule: the model keeps its previous data and expects valid low, so a hold failure shows up at the first falling edge after the idle input. Runs of back-to-back random inputs compare every single clock. This also catches a result that arrives a cycle late or is dropped.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    typedef enum logic [1:0] {
        MODE_LANE_DW  = 2'b00,
        MODE_QW_CROSS = 2'b01,
        MODE_DUAL_SRC = 2'b10,
        MODE_RSVD     = 2'b11
    } shuf_mode_e;

    localparam int FIELD_W    = 2;
    localparam int FIELD_CNT  = 4;
    localparam int IMM_W      = FIELD_W * FIELD_CNT;
    localparam int LANE_ELEMS = 4;
    localparam int NUM_LANES  = 2;
    localparam int OUT_ELEMS  = LANE_ELEMS * NUM_LANES;
    localparam int POOL_ELEMS = 2 * OUT_ELEMS;
    localparam int IDX_W      = $clog2(POOL_ELEMS);

endpackage

// File: rtl/shuf_sel_gen.sv
module shuf_sel_gen
    import shuf_pkg::*;
(
    input  shuf_mode_e                        mode_i,
    input  logic [IMM_W-1:0]                  imm_i,
    output logic [OUT_ELEMS-1:0][IDX_W-1:0]   idx_o,
    output logic [OUT_ELEMS-1:0]              zero_o
);

    // Pool layout: entries 0..OUT_ELEMS-1 are src_a dwords,
    // entries OUT_ELEMS..POOL_ELEMS-1 are src_b dwords.
    for (genvar d = 0; d < OUT_ELEMS; d++) begin : g_elem
        localparam int LANE = d / LANE_ELEMS;
        localparam int POS  = d % LANE_ELEMS;
        localparam int QW   = d / 2;
        localparam int HALF = d % 2;
        localparam int LANE_BASE = LANE * LANE_ELEMS;
        localparam int SRC_BASE  = (POS >= LANE_ELEMS / 2) ? OUT_ELEMS : 0;

        logic [FIELD_W-1:0] pos_field;
        logic [FIELD_W-1:0] qw_field;
        logic [IDX_W-1:0]   idx_l;
        logic               zero_l;

        assign pos_field = imm_i[POS*FIELD_W +: FIELD_W];
        assign qw_field  = imm_i[QW*FIELD_W +: FIELD_W];

        always_comb begin
            idx_l  = '0;
            zero_l = 1'b0;
            unique case (mode_i)
                MODE_LANE_DW:  idx_l = IDX_W'(LANE_BASE) + IDX_W'(pos_field);
                MODE_QW_CROSS: idx_l = IDX_W'({qw_field, 1'(HALF)});
                MODE_DUAL_SRC: idx_l = IDX_W'(SRC_BASE + LANE_BASE) + IDX_W'(pos_field);
                MODE_RSVD:     zero_l = 1'b1;
                default:       zero_l = 1'b1;
            endcase
        end

        assign idx_o[d]  = idx_l;
        assign zero_o[d] = zero_l;
    end

endmodule

// File: rtl/shuf_elem_mux.sv
module shuf_elem_mux #(
    parameter int ELEM_W     = 32,
    parameter int POOL_ELEMS = 16,
    parameter int IDX_W      = 4
) (
    input  logic [POOL_ELEMS-1:0][ELEM_W-1:0] pool_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic                              zero_i,
    output logic [ELEM_W-1:0]                 elem_o
);

    always_comb begin
        if (zero_i) elem_o = '0;
        else        elem_o = pool_i[idx_i];
    end

endmodule

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit
    import shuf_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_vld,
    input  logic [1:0]                    mode,
    input  logic [IMM_W-1:0]              imm,
    input  logic [ELEM_W*OUT_ELEMS-1:0]   src_a,
    input  logic [ELEM_W*OUT_ELEMS-1:0]   src_b,
    output logic                          out_vld,
    output logic [ELEM_W*OUT_ELEMS-1:0]   out_data
);

    localparam int VEC_W = ELEM_W * OUT_ELEMS;
    localparam int QW_W  = 2 * ELEM_W;

    shuf_mode_e                          mode_e;
    logic [POOL_ELEMS-1:0][ELEM_W-1:0]   pool;
    logic [OUT_ELEMS-1:0][IDX_W-1:0]     sel_idx;
    logic [OUT_ELEMS-1:0]                sel_zero;
    logic [OUT_ELEMS-1:0][ELEM_W-1:0]    comb_res;

    assign mode_e = shuf_mode_e'(mode);
    assign pool   = {src_b, src_a};

    shuf_sel_gen u_sel (
        .mode_i (mode_e),
        .imm_i  (imm),
        .idx_o  (sel_idx),
        .zero_o (sel_zero)
    );

    for (genvar d = 0; d < OUT_ELEMS; d++) begin : g_mux
        shuf_elem_mux #(
            .ELEM_W     (ELEM_W),
            .POOL_ELEMS (POOL_ELEMS),
            .IDX_W      (IDX_W)
        ) u_mux (
            .pool_i (pool),
            .idx_i  (sel_idx[d]),
            .zero_i (sel_zero[d]),
            .elem_o (comb_res[d])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_data <= '0;
        else if (in_vld) out_data <= VEC_W'(comb_res);
    end

    // R2: valid timing
    p_vld_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_vld_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R3: lane dword, lower lane element 0
    p_lane_dw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b00) |=>
        out_data[ELEM_W-1:0] == $past(src_a[int'(imm[1:0])*ELEM_W +: ELEM_W]));

    // R4: upper lane reuses field 0 within the upper lane
    p_upper_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b00) |=>
        out_data[LANE_ELEMS*ELEM_W +: ELEM_W] ==
        $past(src_a[(LANE_ELEMS + int'(imm[1:0]))*ELEM_W +: ELEM_W]));

    // R5: qword crossing, output qword 0
    p_qw_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b01) |=>
        out_data[QW_W-1:0] == $past(src_a[int'(imm[1:0])*QW_W +: QW_W]));

    // R6: dual source, lower lane position 2 comes from src_b
    p_dual_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b10) |=>
        out_data[2*ELEM_W +: ELEM_W] == $past(src_b[int'(imm[5:4])*ELEM_W +: ELEM_W]));

    // R7: reserved mode clears the result
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 2'b11) |=> out_data == '0);

    // R9: idle cycles keep the result
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_data));

endmodule

// File: tb/sim_vec_shuffle_unit.sv
module sim_vec_shuffle_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_vld;
    logic [1:0]   mode;
    logic [7:0]   imm;
    logic [W-1:0] src_a;
    logic [W-1:0] src_b;
    logic         out_vld;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    logic         exp_vld;
    logic [W-1:0] exp_data;
    string        pend_tag;
    string        pend_vtag;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_shuffle_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .mode     (mode),
        .imm      (imm),
        .src_a    (src_a),
        .src_b    (src_b),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    function automatic logic [W-1:0] rnd256();
        logic [W-1:0] r;
        for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [W-1:0] ref_fn(input logic [1:0] m, input logic [7:0] im,
                                            input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        int f;
        r = '0;
        case (m)
            2'd0: for (int l = 0; l < 2; l++)
                      for (int k = 0; k < 4; k++) begin
                          f = (im >> (2*k)) & 3;
                          r[32*(4*l+k) +: 32] = a[32*(4*l+f) +: 32];
                      end
            2'd1: for (int q = 0; q < 4; q++) begin
                      f = (im >> (2*q)) & 3;
                      r[64*q +: 64] = a[64*f +: 64];
                  end
            2'd2: for (int l = 0; l < 2; l++)
                      for (int k = 0; k < 4; k++) begin
                          f = (im >> (2*k)) & 3;
                          if (k < 2) r[32*(4*l+k) +: 32] = a[32*(4*l+f) +: 32];
                          else       r[32*(4*l+k) +: 32] = b[32*(4*l+f) +: 32];
                      end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (out_vld !== exp_vld) begin
            errors++;
            $display("FAIL %s out_vld actual=%0b expected=%0b", pend_vtag, out_vld, exp_vld);
        end
        checks++;
        if (out_data !== exp_data) begin
            errors++;
            $display("FAIL %s out_data actual=%h expected=%h", pend_tag, out_data, exp_data);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] m, input logic [7:0] im,
                        input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        compare();
        in_vld = v; mode = m; imm = im; src_a = a; src_b = b;
        exp_vld = v;
        if (v) exp_data = ref_fn(m, im, a, b);
        pend_tag  = v ? tag : "R9";
        pend_vtag = (tag == "R10") ? "R10" : "R2";
    endtask

    initial begin
        logic [W-1:0] pa, pb, pb2;
        for (int i = 0; i < 8; i++) begin
            pa[32*i +: 32] = 32'hA000_0000 + i;
            pb[32*i +: 32] = 32'hB000_0000 + i;
            pb2[32*i +: 32] = 32'hC000_0000 + i;
        end
        rst_n = 1'b0; in_vld = 1'b0; mode = 2'b00; imm = 8'h00; src_a = '0; src_b = '0;
        exp_vld = 1'b0; exp_data = '0; pend_tag = "R1"; pend_vtag = "R1";
        repeat (3) @(negedge clk);
        compare();                                   // R1 during reset
        rst_n = 1'b1;

        step(1'b1, 2'b00, 8'b00_01_10_11, pa, pb, "R3");   // reverse within lanes (R1 checked first)
        step(1'b1, 2'b00, 8'hE4, pa, pb, "R3");            // identity
        step(1'b1, 2'b00, 8'h00, pa, pb, "R4");            // broadcast element 0 per lane
        step(1'b1, 2'b00, 8'hFF, pa, pb, "R4");            // broadcast element 3 per lane
        step(1'b1, 2'b00, 8'h9C, pa, pb, "R8");
        step(1'b1, 2'b00, 8'h9C, pa, pb2, "R8");           // src_b changed, same result
        step(1'b1, 2'b01, 8'h1B, pa, pb, "R5");            // qword reverse, crosses lanes
        step(1'b1, 2'b01, 8'hAA, pa, pb, "R5");            // qword 2 everywhere
        step(1'b1, 2'b01, 8'h1B, pa, pb2, "R8");
        step(1'b1, 2'b10, 8'h4E, pa, pb, "R6");
        step(1'b1, 2'b10, 8'hB1, pa, pb2, "R6");
        step(1'b1, 2'b11, 8'hE4, pa, pb, "R7");
        step(1'b1, 2'b00, 8'h1B, pa, pb, "R3");
        step(1'b0, 2'b01, 8'h55, pb, pa, "R9");            // idle: data must hold
        step(1'b0, 2'b10, 8'hAA, rnd256(), rnd256(), "R9");
        step(1'b0, 2'b11, 8'h00, rnd256(), rnd256(), "R9");
        for (int n = 0; n < 60; n++)
            step(1'b1, 2'($urandom), 8'($urandom), rnd256(), rnd256(), "R10");
        for (int n = 0; n < 40; n++)
            step(1'($urandom), 2'($urandom), 8'($urandom), rnd256(), rnd256(), "R10");
        step(1'b0, 2'b00, 8'h00, '0, '0, "R9");
        step(1'b0, 2'b00, 8'h00, '0, '0, "R9");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule